// File: doc/BRIEF.md
# Up/Down Timer with Two Compare Channels

This block is an 8-bit timer that counts up, or up and then down, on ticks chosen by a 3-bit select field. A tick can come from a free-running divider of the system clock, or from an external input. The external input passes through a synchroniser and then an edge detector. The ceiling of the count is either the all-ones value or the active compare value of channel A. Four modes are available: free-running, clear-on-match, and two phase-correct variants that differ only in their ceiling.

Each of the two compare channels has a holding register written over the bus and an active copy that is compared against the count. A match sets the channel's flag and updates the channel's waveform pin. An overflow flag marks the wrap at the top of the range, or the turn at zero in the phase-correct modes. Software reaches all state through a small register port. The port has a 3-bit address, a write strobe and a combinational read.

Top module: `updown_timer`

## Requirements
- R1: After reset the count, both holding and active compare values, all three flags, both pins, the tick select and the mode are 0, and every register reads 0.
- R2: The tick select field (control bits [2:0]) works as follows: 0 stops counting; 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks; 6 gives a tick for each falling edge of the external input; 7 gives a tick for each rising edge. The external input passes through two synchronising flops before edge detection.
- R3: In mode 0 (control bits [4:3] = 00) each tick adds one to the count, and the count wraps from 0xFF to 0x00. A tick while the count is 0xFF sets the overflow flag in modes 0 and 1.
- R4: In mode 1 the ceiling is the active channel A compare value. A tick while the count equals that ceiling loads 0x00; otherwise the tick adds one.
- R5: Mode 2 (ceiling 0xFF) and mode 3 (ceiling = active channel A value) count up to the ceiling, then down to 0x00, then up again. A tick at the ceiling while counting up turns the direction to down. A tick at 0x00 while counting down turns it to up and sets the overflow flag.
- R6: In modes 0 and 1 the active compare value takes the holding value on every clock. In modes 2 and 3 it takes the holding value only on a tick at which the count equals the ceiling.
- R7: A tick while the count equals a channel's active value sets that channel's match flag.
- R8: On a channel match in modes 0 and 1 the channel's pin toggles. In modes 2 and 3 the pin goes low on a match while counting up and high on a match while counting down.
- R9: Writing the flag register (address 4; bit 0 overflow, bit 1 channel A, bit 2 channel B) with a 1 in a bit clears that flag. A new set event in the same cycle wins over the clear.
- R10: A write to address 1 loads the count. The load takes priority over a tick in the same cycle, and that tick produces no events.
- R11: The register map is: address 0 holds control (select in bits [2:0], mode in bits [4:3]); address 1 holds the count; addresses 2 and 3 hold the channel A and channel B holding values; address 4 holds the flags. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for both read and write |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ext_clk_in | input | 1 | External count source, asynchronous |
| ovf_flag | output | 1 | Overflow flag |
| match_a_flag | output | 1 | Channel A match flag |
| match_b_flag | output | 1 | Channel B match flag |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
The assertions assume that the address, write strobe and write data are known at every clock edge after reset. They also assume that mode changes come only through the control register, so a direction bit left over from a phase-correct mode is cleared on the next clock after leaving it. The random stimulus keeps to this by driving every bus input at the falling edge, with defined values, on every cycle. The random stimulus writes only the stopped and divide-by-one tick selects, so the bench's cycle model always knows when a tick falls. The slower dividers and both external edge polarities are covered by directed runs whose lengths are exact multiples of the tick period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MODE_FREE    = 2'd0,
      MODE_CLR     = 2'd1,
      MODE_TRI_MAX = 2'd2,
      MODE_TRI_CMP = 2'd3
   } tmr_mode_e;

   localparam logic [2:0] ADDR_CTRL  = 3'd0;
   localparam logic [2:0] ADDR_COUNT = 3'd1;
   localparam logic [2:0] ADDR_CMPA  = 3'd2;
   localparam logic [2:0] ADDR_CMPB  = 3'd3;
   localparam logic [2:0] ADDR_FLAGS = 3'd4;

   localparam int NUM_CH = 2;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int SH1         = 3,
   parameter int SH2         = 6,
   parameter int SH3         = 8,
   parameter int SH4         = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       ext_in,
   output logic       tick
);

   initial begin : elab_chk
      if (!(SH1 > 0 && SH1 < SH2 && SH2 < SH3 && SH3 < SH4))
         $fatal(1, "tmr_tick_gen: divider shifts must be increasing and positive");
      if (SYNC_STAGES < 2)
         $fatal(1, "tmr_tick_gen: at least two synchroniser stages required");
   end

   logic [SH4-1:0]       presc_q;
   logic [SYNC_STAGES:0] sync_q;
   logic                 ext_now, ext_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc_q <= '0;
      else        presc_q <= presc_q + 1'b1;
   end

   // synchroniser chain plus one extra stage holding the previous level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
   end

   assign ext_now  = sync_q[SYNC_STAGES-1];
   assign ext_prev = sync_q[SYNC_STAGES];

   always_comb begin
      unique case (sel)
         3'd0:    tick = 1'b0;
         3'd1:    tick = 1'b1;
         3'd2:    tick = &presc_q[SH1-1:0];
         3'd3:    tick = &presc_q[SH2-1:0];
         3'd4:    tick = &presc_q[SH3-1:0];
         3'd5:    tick = &presc_q[SH4-1:0];
         3'd6:    tick = ext_prev & ~ext_now;
         default: tick = ext_now & ~ext_prev;
      endcase
   end

   // R2: an external edge needs a settled synchroniser level on both sides
   p_edge_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd7 && tick) |-> ($past(ext_now) == 1'b0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] top_val,
   output logic [W-1:0] cnt,
   output logic         down,
   output logic         step,
   output logic         top_hit,
   output logic         ovf_evt
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] BOT  = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   logic         phase, at_top;
   logic [W-1:0] cnt_n;
   logic         down_n;

   assign phase   = mode[1];
   assign at_top  = (cnt == top_val);
   assign step    = tick & ~ld;
   assign top_hit = step & at_top;
   assign ovf_evt = step & (phase ? (down && cnt == BOT) : (cnt == MAXV));

   always_comb begin
      cnt_n  = cnt;
      down_n = phase ? down : 1'b0;
      if (ld) begin
         cnt_n = ld_val;
      end else if (tick) begin
         if (!phase) begin
            cnt_n = (mode == MODE_CLR && at_top) ? BOT : cnt + ONE;
         end else if (!down) begin
            if (at_top) begin
               down_n = 1'b1;
               cnt_n  = (top_val == BOT) ? BOT : cnt - ONE;
            end else begin
               cnt_n  = cnt + ONE;
            end
         end else begin
            if (cnt == BOT) begin
               down_n = 1'b0;
               cnt_n  = (top_val == BOT) ? BOT : cnt + ONE;
            end else begin
               cnt_n  = cnt - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b0;
      end else begin
         cnt  <= cnt_n;
         down <= down_n;
      end
   end

   p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_FREE && step) |=> (cnt == $past(cnt) + ONE));

   p_clr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CLR && top_hit) |=> (cnt == BOT));

   p_turn_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && top_hit && !down) |=> down);

   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_we,
   input  logic [W-1:0] wdata,
   input  logic         phase,
   input  logic         copy_evt,
   input  logic         step,
   input  logic [W-1:0] cnt,
   input  logic         down,
   input  logic         flag_clr,
   output logic [W-1:0] hold_q,
   output logic [W-1:0] act_q,
   output logic         flag,
   output logic         pin,
   output logic         match_evt
);

   assign match_evt = step & (cnt == act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         act_q  <= '0;
         flag   <= 1'b0;
         pin    <= 1'b0;
      end else begin
         if (hold_we) hold_q <= wdata;
         if (!phase || copy_evt) act_q <= hold_q;
         if (match_evt)     flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (match_evt) pin <= phase ? down : ~pin;
      end
   end

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag);

   p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && !copy_evt) |=> (act_q == $past(act_q)));

   p_pin_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && match_evt) |=> (pin == $past(down)));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !match_evt) |=> !flag);

endmodule

// File: rtl/updown_timer.sv
module updown_timer
   import tmr_pkg::*;
#(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SH1         = 3,
   parameter int SH2         = 6,
   parameter int SH3         = 8,
   parameter int SH4         = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   bus_addr,
   input  logic         bus_we,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic         ext_clk_in,
   output logic         ovf_flag,
   output logic         match_a_flag,
   output logic         match_b_flag,
   output logic         wave_a,
   output logic         wave_b
);

   localparam logic [W-1:0] MAXV = {W{1'b1}};

   initial begin : elab_chk
      if (W < 5) $fatal(1, "updown_timer: data width must hold the control field");
   end

   logic [2:0]  sel_q;
   tmr_mode_e   mode_q;
   logic        tick, step, top_hit, ovf_evt, down, ld;
   logic [W-1:0] cnt, top_val;

   logic [NUM_CH-1:0][W-1:0] hold_v, act_v;
   logic [NUM_CH-1:0]        flag_v, pin_v, mev_v;

   logic wr_ctrl, wr_flags;
   assign wr_ctrl  = bus_we && bus_addr == ADDR_CTRL;
   assign wr_flags = bus_we && bus_addr == ADDR_FLAGS;
   assign ld       = bus_we && bus_addr == ADDR_COUNT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 3'd0;
         mode_q <= MODE_FREE;
      end else if (wr_ctrl) begin
         sel_q  <= bus_wdata[2:0];
         mode_q <= tmr_mode_e'(bus_wdata[4:3]);
      end
   end

   tmr_tick_gen #(
      .SH1(SH1), .SH2(SH2), .SH3(SH3), .SH4(SH4), .SYNC_STAGES(SYNC_STAGES)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(sel_q), .ext_in(ext_clk_in), .tick(tick)
   );

   assign top_val = mode_q[0] ? act_v[0] : MAXV;

   tmr_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick), .ld(ld),
      .ld_val(bus_wdata), .top_val(top_val), .cnt(cnt), .down(down),
      .step(step), .top_hit(top_hit), .ovf_evt(ovf_evt)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_compare #(.W(W)) u_cmp (
         .clk(clk), .rst_n(rst_n),
         .hold_we(bus_we && bus_addr == 3'(ADDR_CMPA + c)),
         .wdata(bus_wdata), .phase(mode_q[1]), .copy_evt(top_hit),
         .step(step), .cnt(cnt), .down(down),
         .flag_clr(wr_flags && bus_wdata[c+1]),
         .hold_q(hold_v[c]), .act_q(act_v[c]), .flag(flag_v[c]),
         .pin(pin_v[c]), .match_evt(mev_v[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovf_flag <= 1'b0;
      else if (ovf_evt)                ovf_flag <= 1'b1;
      else if (wr_flags && bus_wdata[0]) ovf_flag <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CTRL: begin
            bus_rdata[2:0] = sel_q;
            bus_rdata[4:3] = mode_q;
         end
         ADDR_COUNT: bus_rdata = cnt;
         ADDR_CMPA:  bus_rdata = hold_v[0];
         ADDR_CMPB:  bus_rdata = hold_v[1];
         ADDR_FLAGS: bus_rdata[2:0] = {flag_v[1], flag_v[0], ovf_flag};
         default:    bus_rdata = '0;
      endcase
   end

   assign match_a_flag = flag_v[0];
   assign match_b_flag = flag_v[1];
   assign wave_a       = pin_v[0];
   assign wave_b       = pin_v[1];

   p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == 3'd0) |-> !tick);

   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);

   p_b_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[1] |=> (act_v[1] == $past(hold_v[1])));

   p_match_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mev_v != '0) |-> step);

endmodule

// File: tb/updown_timer_test.sv
module updown_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tb_addr = 3'd0;
   logic       tb_we = 1'b0;
   logic [7:0] tb_wdata = 8'd0;
   logic       tb_ext = 1'b0;
   logic [7:0] rdata;
   logic       ovf, fa, fb, pa, pb;

   int checks = 0;
   int fails  = 0;
   bit model_on = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   updown_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(tb_addr), .bus_we(tb_we),
      .bus_wdata(tb_wdata), .bus_rdata(rdata), .ext_clk_in(tb_ext),
      .ovf_flag(ovf), .match_a_flag(fa), .match_b_flag(fb),
      .wave_a(pa), .wave_b(pb)
   );

   // ---------------- cycle model built from the requirements ----------------
   logic [7:0] m_cnt, m_hold0, m_hold1, m_act0, m_act1;
   logic       m_down, m_ovf, m_f0, m_f1, m_p0, m_p1;
   logic [2:0] m_sel;
   logic [1:0] m_mode;
   logic [7:0] n_cnt, t_top;
   logic       n_down, t_phase, t_tick, t_ld, t_step, t_m0, t_m1, t_ovfe, t_fclr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_hold0 = 0; m_hold1 = 0; m_act0 = 0; m_act1 = 0;
         m_down = 0; m_ovf = 0; m_f0 = 0; m_f1 = 0; m_p0 = 0; m_p1 = 0;
         m_sel = 0; m_mode = 0;
      end else begin
         t_phase = m_mode[1];
         t_top   = m_mode[0] ? m_act0 : 8'hFF;
         t_tick  = (m_sel == 3'd1);                       // R2 divide-by-one
         t_ld    = tb_we && tb_addr == 3'd1;                // R10
         t_step  = t_tick && !t_ld;
         t_fclr  = tb_we && tb_addr == 3'd4;                // R9
         t_m0    = t_step && m_cnt == m_act0;               // R7
         t_m1    = t_step && m_cnt == m_act1;
         t_ovfe  = t_step && (t_phase ? (m_down && m_cnt == 0) : (m_cnt == 8'hFF));
         n_cnt   = m_cnt;
         n_down  = t_phase ? m_down : 1'b0;
         if (t_ld) n_cnt = tb_wdata;
         else if (t_tick) begin
            if (!t_phase) n_cnt = (m_mode == 2'd1 && m_cnt == t_top) ? 8'd0 : m_cnt + 8'd1;
            else if (!m_down) begin
               if (m_cnt == t_top) begin n_down = 1; n_cnt = (t_top == 0) ? 8'd0 : m_cnt - 8'd1; end
               else n_cnt = m_cnt + 8'd1;
            end else begin
               if (m_cnt == 0) begin n_down = 0; n_cnt = (t_top == 0) ? 8'd0 : 8'd1; end
               else n_cnt = m_cnt - 8'd1;
            end
         end
         // R6 active copies
         if (!t_phase || (t_step && m_cnt == t_top)) begin
            m_act0 = m_hold0; m_act1 = m_hold1;
         end
         // R8 pins
         if (t_m0) m_p0 = t_phase ? m_down : ~m_p0;
         if (t_m1) m_p1 = t_phase ? m_down : ~m_p1;
         // R9 flags
         if (t_m0) m_f0 = 1; else if (t_fclr && tb_wdata[1]) m_f0 = 0;
         if (t_m1) m_f1 = 1; else if (t_fclr && tb_wdata[2]) m_f1 = 0;
         if (t_ovfe) m_ovf = 1; else if (t_fclr && tb_wdata[0]) m_ovf = 0;
         // R11 register writes
         if (tb_we && tb_addr == 3'd0) begin m_sel = tb_wdata[2:0]; m_mode = tb_wdata[4:3]; end
         if (tb_we && tb_addr == 3'd2) m_hold0 = tb_wdata;
         if (tb_we && tb_addr == 3'd3) m_hold1 = tb_wdata;
         m_cnt = n_cnt; m_down = n_down;
      end
   end

   function automatic logic [7:0] model_read(input logic [2:0] a);
      case (a)
         3'd0:    return {3'b000, m_mode, m_sel};
         3'd1:    return m_cnt;
         3'd2:    return m_hold0;
         3'd3:    return m_hold1;
         3'd4:    return {5'b00000, m_f1, m_f0, m_ovf};
         default: return 8'd0;
      endcase
   endfunction

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'd0:    return "R3 R7 R8 R9 R10 R11 free-run";
         2'd1:    return "R4 R7 R8 R9 R10 R11 clear-on-match";
         2'd2:    return "R5 R6 R7 R8 R9 R10 phase ceiling=max";
         default: return "R5 R6 R7 R8 R9 R10 phase ceiling=A";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge: one write pulse, returns at the next falling edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      tb_we = 1'b1; tb_addr = a; tb_wdata = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
      tb_addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic presc_run(input logic [2:0] sel, input int cycles, input string tag);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd0, {5'b00000, sel});
      repeat (cycles) @(negedge clk);
      read_check(tag, 3'd1, 8'd10);
   endtask

   task automatic ext_run(input logic [2:0] sel, input string tag);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd0, {5'b00000, sel});
      for (int k = 0; k < 5; k++) begin
         tb_ext = 1'b1; repeat (6) @(negedge clk);
         tb_ext = 1'b0; repeat (6) @(negedge clk);
      end
      read_check(tag, 3'd1, 8'd5);
   endtask

   // per-cycle comparison against the model
   task automatic random_phase(input logic [1:0] mode, input int cycles);
      wr(3'd0, {3'b000, mode, 3'b001});
      for (int i = 0; i < cycles; i++) begin
         if (model_on)
            check(mode_tag(mode), {19'd0, rdata, ovf, fa, fb, pa, pb},
                  {19'd0, model_read(tb_addr), m_ovf, m_f0, m_f1, m_p0, m_p1});
         tb_addr  = 3'($urandom % 8);
         tb_wdata = 8'($urandom);
         tb_we    = ($urandom % 6) == 0;
         if (tb_we && tb_addr == 3'd0) begin
            if (($urandom % 8) != 0) tb_addr = 3'd4;
            else tb_wdata = {3'b000, mode, 2'b00, 1'($urandom % 4 != 0)};
         end
         if (tb_we && tb_addr == 3'd2 && mode[1] && ($urandom % 2) == 0)
            tb_wdata = 8'd8 + 8'($urandom % 40);
         @(negedge clk);
      end
      tb_we = 1'b0;
   endtask

   initial begin : watchdog
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) read_check("R1 reset register", 3'(a), 8'd0);
      check("R1 reset outputs", {ovf, fa, fb, pa, pb}, 5'd0);

      // R11 readback of holding registers and unmapped address
      wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd6, 8'hFF);
      read_check("R11 channel A holding", 3'd2, 8'h5A);
      read_check("R11 channel B holding", 3'd3, 8'hC3);
      read_check("R11 unmapped reads zero", 3'd6, 8'h00);

      // R2 stopped: count does not move
      wr(3'd1, 8'h33);
      repeat (50) @(negedge clk);
      read_check("R2 select 0 holds count", 3'd1, 8'h33);

      model_on = 1'b1;
      random_phase(2'd0, 3000);
      random_phase(2'd1, 3000);
      random_phase(2'd2, 4000);
      random_phase(2'd3, 4000);
      random_phase(2'd1, 1500);
      model_on = 1'b0;

      // R2 dividers and external edges
      presc_run(3'd2, 80,    "R2 divide by 8");
      presc_run(3'd3, 640,   "R2 divide by 64");
      presc_run(3'd4, 2560,  "R2 divide by 256");
      presc_run(3'd5, 10240, "R2 divide by 1024");
      ext_run(3'd7, "R2 external rising edges");
      ext_run(3'd6, "R2 external falling edges");

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule